// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Control Register File

This block holds the control state that software programs into a two-channel bus-master disk DMA engine. It sits behind a 16-byte I/O window on a simple host register bus. Address bit 3 picks one of two 8-byte channel banks, and the three low address bits pick a register inside that bank. Each bank holds a command register, a status register and a 32-bit descriptor-table pointer.

The engine sees three things for each channel: the start and direction bits, and a dword-aligned descriptor pointer. It reports back through single-cycle pulses that raise the error and interrupt flags in the status register. Software clears those flags by writing ones to them. Writing the start bit also sets or clears the status active flag, so software can poll a single register.

Each register has one allowed access width. An access of any other width, or an access to an offset that holds no register, never changes state, and a read of it returns all ones. Read data is registered: it appears one cycle after the read strobe and holds until the next read.

Top module: `bmdma_regfile`

## Requirements
- R1: Address bit 3 selects the channel (0 or 1) and bits 2:0 select the register: 0 is command, 2 is status and 4 is pointer. A read at offset 1, 3, 5, 6 or 7 returns 0xFFFFFFFF, and a write there changes no register.
- R2: A byte write to the command register (offset 0) stores only bits 0 and 3, and every other bit reads back as zero. Bit 0 drives that channel's start output and bit 3 drives its direction output.
- R3: A command write sets status bit 0 (active) to the value of written bit 0. When bit 0 is 1 the flag is set, and when bit 0 is 0 the flag is cleared.
- R4: A byte write to the status register (offset 2) works as follows. Bits 5 and 6 take the written value. Bit 0 keeps its value. Bits 1 and 2 clear where a 1 is written and keep their value where a 0 is written. Bits 3, 4 and 7 always read as zero.
- R5: A 4-byte write to the pointer register (offset 4) stores all 32 data bits, and a 4-byte read returns them unchanged. The pointer output of that channel shows the stored value with bits 1:0 forced to zero.
- R6: Offsets 0 and 2 accept only length 1, and offset 4 accepts only length 4. A write of any other length is ignored, and a read of any other length returns 0xFFFFFFFF.
- R7: Synchronous reset clears the command, status and pointer registers of both channels to zero. It also clears the read data to zero.
- R8: A pulse on a channel's error-set input sets status bit 1 on the next clock, and a pulse on its interrupt-set input sets bit 2. A set pulse wins over a write-one-to-clear of the same bit in the same cycle.
- R9: Read data is captured on the clock edge where the read strobe is high, and it holds until the next read. A byte register is returned zero-extended to 32 bits.
- R10: The two channels are independent. No access to one channel changes any register or output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_len | input | 3 | Access length in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data; byte registers use bits 7:0 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| eng_err_set | input | 2 | Per-channel error-flag set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt-flag set pulse |
| ch_start | output | 2 | Per-channel start bit |
| ch_dir | output | 2 | Per-channel direction bit |
| ch_desc_ptr | output | 64 | Per-channel descriptor pointer, channel 0 in bits 31:0, low two bits zero |

## Verification
The start and direction bits and the pointer are outputs, so a wrong command or pointer value shows at the ports on the clock right after the faulty write. The status register has no port of its own. A wrong active, error or interrupt flag, or a reserved bit that has gone high, shows only in the first status read after the fault, and then one cycle after that read's strobe. The bench therefore reads status after every status-affecting event and compares every cycle's outputs and read data with a behavioural model. A write decoded into the wrong channel shows up in the other channel's outputs at once.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int BANK_BITS = 3;

    localparam logic [BANK_BITS-1:0] OFF_CMD  = 3'd0;
    localparam logic [BANK_BITS-1:0] OFF_STAT = 3'd2;
    localparam logic [BANK_BITS-1:0] OFF_PTR  = 3'd4;

    localparam logic [2:0] LEN_BYTE  = 3'd1;
    localparam logic [2:0] LEN_DWORD = 3'd4;

    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;
    localparam int ST_ACTIVE = 0;
    localparam int ST_ERR    = 1;
    localparam int ST_IRQ    = 2;

    localparam logic [BYTE_W-1:0] CMD_MASK  = 8'h09;
    localparam logic [BYTE_W-1:0] STAT_RW   = 8'h60;
    localparam logic [BYTE_W-1:0] STAT_KEEP = 8'h01;
    localparam logic [BYTE_W-1:0] STAT_W1C  = 8'h06;

    localparam logic [DATA_W-1:0] RD_MISS = '1;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_PTR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr;
        logic     rd;
    } acc_t;

    function automatic logic [BYTE_W-1:0] stat_merge(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] wb
    );
        return (wb & STAT_RW) | (cur & STAT_KEEP) | (cur & ~wb & STAT_W1C);
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    localparam int CH_W  = ADDR_W - BANK_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        len,
    input  logic              wr,
    input  logic              rd,
    output acc_t              acc,
    output logic [CH_W-1:0]   ch_idx,
    output logic [NUM_CH-1:0] ch_hit
);

    logic [BANK_BITS-1:0] off;

    assign off    = addr[BANK_BITS-1:0];
    assign ch_idx = addr[ADDR_W-1:BANK_BITS];

    always_comb begin
        acc.wr  = wr;
        acc.rd  = rd;
        acc.sel = SEL_NONE;
        if (off == OFF_CMD && len == LEN_BYTE)
            acc.sel = SEL_CMD;
        else if (off == OFF_STAT && len == LEN_BYTE)
            acc.sel = SEL_STAT;
        else if (off == OFF_PTR && len == LEN_DWORD)
            acc.sel = SEL_PTR;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = (ch_idx == CH_W'(i));
    end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_set,
    input  logic              irq_set,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [DATA_W-1:0] ptr_q
);

    logic              wr_hit;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] stat_nx;

    assign wr_hit = acc.wr && hit;
    assign wbyte  = wdata[BYTE_W-1:0];

    always_comb begin
        stat_nx = stat_q;
        if (wr_hit && acc.sel == SEL_CMD)
            stat_nx[ST_ACTIVE] = wbyte[CMD_START];
        if (wr_hit && acc.sel == SEL_STAT)
            stat_nx = stat_merge(stat_q, wbyte);
        if (err_set)
            stat_nx[ST_ERR] = 1'b1;
        if (irq_set)
            stat_nx[ST_IRQ] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            ptr_q  <= '0;
        end else begin
            stat_q <= stat_nx;
            if (wr_hit && acc.sel == SEL_CMD)
                cmd_q <= wbyte & CMD_MASK;
            if (wr_hit && acc.sel == SEL_PTR)
                ptr_q <= wdata;
        end
    end

endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  reg_sel_e                       sel,
    input  logic [CH_W-1:0]                ch_idx,
    input  logic [NUM_CH-1:0][BYTE_W-1:0]  cmd,
    input  logic [NUM_CH-1:0][BYTE_W-1:0]  stat,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ptr,
    output logic [DATA_W-1:0]              rdata
);

    always_comb begin
        unique case (sel)
            SEL_CMD:  rdata = DATA_W'(cmd[ch_idx]);
            SEL_STAT: rdata = DATA_W'(stat[ch_idx]);
            SEL_PTR:  rdata = ptr[ch_idx];
            default:  rdata = RD_MISS;
        endcase
    end

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int NUM_CH  = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = BANK_BITS + CH_W,
    localparam int PTR_W  = NUM_CH * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_len,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] eng_err_set,
    input  logic [NUM_CH-1:0] eng_irq_set,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_dir,
    output logic [PTR_W-1:0]  ch_desc_ptr
);

    acc_t                          acc;
    logic [CH_W-1:0]               ch_idx;
    logic [NUM_CH-1:0]             ch_hit;
    logic [NUM_CH-1:0][BYTE_W-1:0] cmd_all;
    logic [NUM_CH-1:0][BYTE_W-1:0] stat_all;
    logic [NUM_CH-1:0][DATA_W-1:0] ptr_all;
    logic [NUM_CH*BYTE_W-1:0]      stat_flat;
    logic [DATA_W-1:0]             rd_next;

    bmdma_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .len    (bus_len),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .acc    (acc),
        .ch_idx (ch_idx),
        .ch_hit (ch_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        bmdma_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .acc     (acc),
            .hit     (ch_hit[i]),
            .wdata   (bus_wdata),
            .err_set (eng_err_set[i]),
            .irq_set (eng_irq_set[i]),
            .cmd_q   (cmd_all[i]),
            .stat_q  (stat_all[i]),
            .ptr_q   (ptr_all[i])
        );
        assign ch_start[i] = cmd_all[i][CMD_START];
        assign ch_dir[i]   = cmd_all[i][CMD_DIR];
        assign ch_desc_ptr[i*DATA_W +: DATA_W] = {ptr_all[i][DATA_W-1:2], 2'b00};
        assign stat_flat[i*BYTE_W +: BYTE_W]   = stat_all[i];
    end

    bmdma_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rdmux (
        .sel    (acc.sel),
        .ch_idx (ch_idx),
        .cmd    (cmd_all),
        .stat   (stat_all),
        .ptr    (ptr_all),
        .rdata  (rd_next)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (acc.rd)
            bus_rdata <= rd_next;
    end

endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2:0]          bus_len,
    input logic [31:0]         bus_wdata,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [31:0]         bus_rdata,
    input logic [NUM_CH-1:0]   eng_err_set,
    input logic [NUM_CH-1:0]   eng_irq_set,
    input logic [NUM_CH-1:0]   ch_start,
    input logic [NUM_CH-1:0]   ch_dir,
    input logic [NUM_CH*32-1:0] ch_desc_ptr,
    input logic [NUM_CH*8-1:0]  stat_vec
);

    logic [2:0] off;
    assign off = bus_addr[2:0];

    p_undecoded_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (off == 3'd1 || off == 3'd3 || off >= 3'd5)) |=> bus_rdata == 32'hFFFF_FFFF);

    p_cmd_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && off == 3'd0 && bus_len == 3'd1) |=> (bus_rdata & 32'hFFFF_FFF6) == 32'h0);

    p_bad_len_write_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && off == 3'd0 && bus_len != 3'd1) |=> ($stable(ch_start) && $stable(ch_dir)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        p_active_tracks_start_r3: assert property (@(posedge clk) disable iff (rst)
            ch_start[i] == stat_vec[i*8]);

        p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
            (stat_vec[i*8+3] == 1'b0) && (stat_vec[i*8+4] == 1'b0) && (stat_vec[i*8+7] == 1'b0));

        p_err_pulse_sets_r8: assert property (@(posedge clk) disable iff (rst)
            eng_err_set[i] |=> stat_vec[i*8+1]);

        p_irq_pulse_sets_r8: assert property (@(posedge clk) disable iff (rst)
            eng_irq_set[i] |=> stat_vec[i*8+2]);

        p_ptr_write_r5: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && off == 3'd4 && bus_len == 3'd4 && bus_addr[ADDR_W-1:3] == i)
            |=> ch_desc_ptr[i*32 +: 32] == {$past(bus_wdata[31:2]), 2'b00});
    end

endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_len     (bus_len),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .eng_err_set (eng_err_set),
    .eng_irq_set (eng_irq_set),
    .ch_start    (ch_start),
    .ch_dir      (ch_dir),
    .ch_desc_ptr (ch_desc_ptr),
    .stat_vec    (stat_flat)
);

// File: tb/sim_bmdma_regfile.sv
`timescale 1ns/1ps
module sim_bmdma_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [2:0]  bus_len = 3'd1;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  eng_err_set = '0;
    logic [1:0]  eng_irq_set = '0;
    logic [1:0]  ch_start;
    logic [1:0]  ch_dir;
    logic [63:0] ch_desc_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bmdma_regfile u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .eng_err_set(eng_err_set),
        .eng_irq_set(eng_irq_set), .ch_start(ch_start), .ch_dir(ch_dir),
        .ch_desc_ptr(ch_desc_ptr)
    );

    // Behavioural reference model
    logic [7:0]  m_cmd [2];
    logic [7:0]  m_st  [2];
    logic [31:0] m_ptr [2];
    logic [31:0] m_rd;

    always @(posedge clk) begin
        int c;
        int o;
        c = int'(bus_addr[3]);
        o = int'(bus_addr[2:0]);
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                m_cmd[k] = 0; m_st[k] = 0; m_ptr[k] = 0;
            end
            m_rd = 0;
        end else begin
            if (bus_rd) begin
                if (o == 0 && bus_len == 1)      m_rd = {24'h0, m_cmd[c]};
                else if (o == 2 && bus_len == 1) m_rd = {24'h0, m_st[c]};
                else if (o == 4 && bus_len == 4) m_rd = m_ptr[c];
                else                             m_rd = 32'hFFFF_FFFF;
            end
            if (bus_wr) begin
                if (o == 0 && bus_len == 1) begin
                    m_cmd[c] = bus_wdata[7:0] & 8'h09;
                    m_st[c][0] = bus_wdata[0];
                end else if (o == 2 && bus_len == 1) begin
                    m_st[c] = (bus_wdata[7:0] & 8'h60) | (m_st[c] & 8'h01)
                            | (m_st[c] & ~bus_wdata[7:0] & 8'h06);
                end else if (o == 4 && bus_len == 4) begin
                    m_ptr[c] = bus_wdata;
                end
            end
            for (int k = 0; k < 2; k++) begin
                if (eng_err_set[k]) m_st[k][1] = 1'b1;
                if (eng_irq_set[k]) m_st[k][2] = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            for (int k = 0; k < 2; k++) begin
                chk("R2 start", 32'(ch_start[k]), 32'(m_cmd[k][0]));
                chk("R2 dir",   32'(ch_dir[k]),   32'(m_cmd[k][3]));
                chk("R5 ptr",   ch_desc_ptr[k*32 +: 32], m_ptr[k] & 32'hFFFF_FFFC);
            end
            chk("R9 rdata", bus_rdata, m_rd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [2:0] l, input logic [31:0] d,
                      input logic [1:0] es = 2'b00, input logic [1:0] is = 2'b00);
        @(negedge clk);
        bus_addr = a; bus_len = l; bus_wdata = d; bus_wr = 1'b1;
        eng_err_set = es; eng_irq_set = is;
        @(negedge clk);
        bus_wr = 1'b0; eng_err_set = 0; eng_irq_set = 0;
    endtask

    task automatic pulse(input logic [1:0] es, input logic [1:0] is);
        @(negedge clk);
        eng_err_set = es; eng_irq_set = is;
        @(negedge clk);
        eng_err_set = 0; eng_irq_set = 0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [2:0] l,
                      input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_len = l; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state
        chk("R7 rdata", bus_rdata, 32'h0);
        chk("R7 start", 32'(ch_start), 32'h0);
        rd("R7 cmd0", 4'h0, 3'd1, 32'h0);
        rd("R7 stat1", 4'hA, 3'd1, 32'h0);
        rd("R7 ptr1", 4'hC, 3'd4, 32'h0);

        // R2, R3: command write keeps bits 0 and 3, mirrors start to active
        wr(4'h0, 3'd1, 32'h0000_00FF);
        rd("R2 cmd0 mask", 4'h0, 3'd1, 32'h09);
        chk("R2 start0", 32'(ch_start[0]), 32'h1);
        chk("R2 dir0", 32'(ch_dir[0]), 32'h1);
        rd("R3 active set", 4'h2, 3'd1, 32'h01);
        wr(4'h0, 3'd1, 32'h0000_0008);
        rd("R3 active clear", 4'h2, 3'd1, 32'h00);
        chk("R3 start0 low", 32'(ch_start[0]), 32'h0);

        // R10: channel 1 untouched by channel 0 traffic
        rd("R10 cmd1", 4'h8, 3'd1, 32'h0);
        chk("R10 start1", 32'(ch_start[1]), 32'h0);

        // R4: status field behaviour on channel 1
        wr(4'hA, 3'd1, 32'h0000_00FF);
        rd("R4 rw bits", 4'hA, 3'd1, 32'h60);
        pulse(2'b10, 2'b10);
        rd("R8 flags set", 4'hA, 3'd1, 32'h66);
        wr(4'hA, 3'd1, 32'h0000_0002);
        rd("R4 w1c err", 4'hA, 3'd1, 32'h04);
        wr(4'h8, 3'd1, 32'h0000_0001);
        wr(4'hA, 3'd1, 32'h0000_0000);
        rd("R4 active kept", 4'hA, 3'd1, 32'h05);
        wr(4'hA, 3'd1, 32'h0000_009E);
        rd("R4 reserved zero", 4'hA, 3'd1, 32'h01);

        // R8: set wins over same-cycle clear
        pulse(2'b00, 2'b01);
        wr(4'h2, 3'd1, 32'h0000_0004, 2'b00, 2'b01);
        rd("R8 set beats clear", 4'h2, 3'd1, 32'h04);

        // R5: pointer
        wr(4'hC, 3'd4, 32'h1234_5677);
        rd("R5 ptr1 readback", 4'hC, 3'd4, 32'h1234_5677);
        chk("R5 ptr1 aligned", ch_desc_ptr[63:32], 32'h1234_5674);
        chk("R10 ptr0 untouched", ch_desc_ptr[31:0], 32'h0);

        // R6: wrong length
        wr(4'hC, 3'd1, 32'hAAAA_AAAA);
        rd("R6 ptr byte write ignored", 4'hC, 3'd4, 32'h1234_5677);
        rd("R6 cmd dword read", 4'h8, 3'd4, 32'hFFFF_FFFF);
        wr(4'h8, 3'd2, 32'h0000_0000);
        chk("R6 cmd word write ignored", 32'(ch_start[1]), 32'h1);
        rd("R6 stat word read", 4'h2, 3'd2, 32'hFFFF_FFFF);

        // R1: undecoded offsets
        rd("R1 off1", 4'h1, 3'd1, 32'hFFFF_FFFF);
        rd("R1 off5", 4'hD, 3'd1, 32'hFFFF_FFFF);
        rd("R1 off7", 4'h7, 3'd4, 32'hFFFF_FFFF);
        wr(4'h6, 3'd4, 32'hFFFF_FFFF);
        wr(4'h1, 3'd1, 32'hFF);
        rd("R1 write ignored", 4'h0, 3'd1, 32'h08);

        // R9: read data holds between reads
        rd("R9 read", 4'hC, 3'd4, 32'h1234_5677);
        repeat (3) @(negedge clk);
        chk("R9 hold", bus_rdata, 32'h1234_5677);

        done = 1;
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule